// File: doc/BRIEF.md
# Legacy Low-Memory Region Router

This block sits on the host side of a memory controller. It looks at every access below the 1 MB line and decides whether main DRAM serves it, whether it is passed on to the expansion bus, or whether it is refused. The lowest 512 KB always goes to DRAM. The next 128 KB goes to DRAM unless a hole bit sends it to the bus. The 128 KB video window normally goes to the bus, but it becomes private DRAM for system-management code when SMRAM is enabled. Thirteen 16 KB and 64 KB segments in the upper 256 KB each take their own read and write permissions.

Software programs the block through a small indexed register port. Each request is presented for one cycle with its address, direction, SMM flag and initiator flag. One cycle later the block raises exactly one of three strobes: DRAM, bus or denied. For addresses at or above 1 MB it raises none of them.

Top module: `legacy_mem_router`

## Requirements
- R1: After reset, all three outputs are low and every configuration index reads back as zero.
- R2: Any valid access to 00000h–7FFFFh is routed to DRAM, whatever the configuration.
- R3: A valid access to 80000h–9FFFFh goes to DRAM when bit 0 (hole) of index 0 is clear, and to the bus when it is set.
- R4: A host access to A0000h–BFFFFh made outside SMM goes to the bus, whatever the segment attributes.
- R5: A host access to A0000h–BFFFFh made in SMM goes to DRAM when bit 1 (SMRAM) of index 0 is set, and to the bus when it is clear.
- R6: A bus-initiator access to A0000h–BFFFFh raises only the denied flag when SMRAM is set, whatever its SMM flag, and goes to the bus when SMRAM is clear.
- R7: Attribute index 1+k covers the 16 KB segment at C0000h+k·4000h for k=0..7, and index 9+k covers E0000h+k·4000h for k=0..3. Index 13 covers the whole range F0000h–FFFFFh. In each attribute index, bit 0 is read-enable and bit 1 is write-enable.
- R8: In an attribute segment, a read goes to DRAM only when its read-enable is set, and a write goes to DRAM only when its write-enable is set. Any other access goes to the bus.
- R9: An access at or above 100000h raises no output.
- R10: The outputs are registered. They reflect the request from the previous cycle, at most one of them is high, and none is high after a cycle with no valid request.
- R11: Configuration indices read back the stored bits and zeros in all other bits. Writes to indices 14 and 15 are ignored, and those indices read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration index |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data for cfgAddr (combinational) |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Request byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSmm | input | 1 | Requester is in system-management mode |
| reqFromBus | input | 1 | 1 = bus-master initiator, 0 = host |
| toDram | output | 1 | Previous request routed to DRAM |
| toBus | output | 1 | Previous request forwarded to the bus |
| denied | output | 1 | Previous request refused |

## Verification
The assertions assume that the request inputs are stable and meaningful only when reqValid is high. They also assume that a configuration write and a request in the same cycle see the old configuration. The bench keeps to this by issuing configuration writes only in cycles where reqValid is low, and it changes all inputs just after the falling edge. A behavioural model tracks the configuration, predicts the route for every request, and is compared with the strobes on every cycle. This covers a full sweep of every attribute segment for reads and writes.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  localparam int unsigned LMR_NUM_SEG = 13;

  typedef struct packed {
    logic dram;
    logic bus;
    logic deny;
  } route_t;
endpackage

// File: rtl/lmr_control.sv
module lmr_control
  import lmr_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CFG_AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic [CFG_AW-1:0]      cfgAddr,
  input  logic [DW-1:0]          cfgWrData,
  input  logic                   reqValid,
  input  logic [AW-1:0]          reqAddr,
  input  logic                   reqWrite,
  input  logic                   reqSmm,
  input  logic                   reqFromBus,
  output route_t                 route,
  output logic                   holeEn,
  output logic                   smramEn,
  output logic [LMR_NUM_SEG-1:0] segRdEn,
  output logic [LMR_NUM_SEG-1:0] segWrEn
);
  localparam int unsigned IDX_W = $clog2(LMR_NUM_SEG);

  // global control bits at index 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holeEn  <= 1'b0;
      smramEn <= 1'b0;
    end else if (cfgWrEn && cfgAddr == '0) begin
      holeEn  <= cfgWrData[0];
      smramEn <= cfgWrData[1];
    end
  end

  // one attribute pair per segment at index g+1
  for (genvar g = 0; g < LMR_NUM_SEG; g++) begin : gSegAttr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        segRdEn[g] <= 1'b0;
        segWrEn[g] <= 1'b0;
      end else if (cfgWrEn && cfgAddr == CFG_AW'(g + 1)) begin
        segRdEn[g] <= cfgWrData[0];
        segWrEn[g] <= cfgWrData[1];
      end
    end
  end

  logic [19:0]      lowAddr;
  logic             outside, inDos, inExt, inVideo;
  logic [IDX_W-1:0] segIdx;
  logic             segAllow;

  always_comb begin
    lowAddr = reqAddr[19:0];
    outside = |reqAddr[AW-1:20];
    inDos   = !lowAddr[19];
    inExt   = lowAddr[19:17] == 3'b100;
    inVideo = lowAddr[19:17] == 3'b101;
    if (!lowAddr[17])      segIdx = IDX_W'(lowAddr[16:14]);
    else if (!lowAddr[16]) segIdx = IDX_W'(8 + lowAddr[15:14]);
    else                   segIdx = IDX_W'(12);
    segAllow = reqWrite ? segWrEn[segIdx] : segRdEn[segIdx];

    route = '0;
    if (reqValid && !outside) begin
      if (inDos) begin
        route.dram = 1'b1;
      end else if (inExt) begin
        route.dram = !holeEn;
        route.bus  = holeEn;
      end else if (inVideo) begin
        if (reqFromBus) begin
          route.deny = smramEn;
          route.bus  = !smramEn;
        end else begin
          route.dram = reqSmm && smramEn;
          route.bus  = !(reqSmm && smramEn);
        end
      end else begin
        route.dram = segAllow;
        route.bus  = !segAllow;
      end
    end
  end

  assert_low_dram_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr < AW'('h80000)) |-> (route.dram && !route.bus && !route.deny));

  assert_high_none_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= AW'('h100000)) |-> (route == '0));

  assert_bus_deny_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqFromBus && smramEn && reqAddr >= AW'('hA0000) && reqAddr < AW'('hC0000))
      |-> (route.deny && !route.dram));

  assert_video_host_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFromBus && !reqSmm && reqAddr >= AW'('hA0000) && reqAddr < AW'('hC0000))
      |-> route.bus);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!holeEn && !smramEn && segRdEn == '0 && segWrEn == '0));
endmodule

// File: rtl/lmr_datapath.sv
module lmr_datapath
  import lmr_pkg::*;
#(
  parameter int unsigned CFG_AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  route_t                 route,
  input  logic                   holeEn,
  input  logic                   smramEn,
  input  logic [LMR_NUM_SEG-1:0] segRdEn,
  input  logic [LMR_NUM_SEG-1:0] segWrEn,
  input  logic [CFG_AW-1:0]      cfgAddr,
  output logic [DW-1:0]          cfgRdData,
  output logic                   toDram,
  output logic                   toBus,
  output logic                   denied
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      toDram <= 1'b0;
      toBus  <= 1'b0;
      denied <= 1'b0;
    end else begin
      toDram <= route.dram;
      toBus  <= route.bus;
      denied <= route.deny;
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgAddr == '0) begin
      cfgRdData[0] = holeEn;
      cfgRdData[1] = smramEn;
    end else begin
      for (int i = 0; i < LMR_NUM_SEG; i++) begin
        if (cfgAddr == CFG_AW'(i + 1)) begin
          cfgRdData[0] = segRdEn[i];
          cfgRdData[1] = segWrEn[i];
        end
      end
    end
  end

  assert_onehot_out_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({toDram, toBus, denied}));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    (route.dram || route.bus || route.deny) |=> (toDram || toBus || denied));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (route == '0) |=> (!toDram && !toBus && !denied));
endmodule

// File: rtl/legacy_mem_router.sv
module legacy_mem_router
  import lmr_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CFG_AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [DW-1:0]     cfgWrData,
  output logic [DW-1:0]     cfgRdData,
  input  logic              reqValid,
  input  logic [AW-1:0]     reqAddr,
  input  logic              reqWrite,
  input  logic              reqSmm,
  input  logic              reqFromBus,
  output logic              toDram,
  output logic              toBus,
  output logic              denied
);
  route_t                 route;
  logic                   holeEn, smramEn;
  logic [LMR_NUM_SEG-1:0] segRdEn, segWrEn;

  lmr_control #(.AW(AW), .CFG_AW(CFG_AW), .DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSmm(reqSmm),
    .reqFromBus(reqFromBus), .route(route), .holeEn(holeEn), .smramEn(smramEn),
    .segRdEn(segRdEn), .segWrEn(segWrEn)
  );

  lmr_datapath #(.CFG_AW(CFG_AW), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .route(route), .holeEn(holeEn), .smramEn(smramEn),
    .segRdEn(segRdEn), .segWrEn(segWrEn), .cfgAddr(cfgAddr), .cfgRdData(cfgRdData),
    .toDram(toDram), .toBus(toBus), .denied(denied)
  );
endmodule

// File: tb/legacy_mem_router_test.sv
module legacy_mem_router_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0, reqSmm = 1'b0, reqFromBus = 1'b0;
  logic        toDram, toBus, denied;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit mHole = 0, mSmram = 0;
  bit mRd [13];
  bit mWr [13];
  // expected outputs {dram,bus,deny} and tag of the pending request
  logic [2:0] expOut = 3'b000;
  string      expTag = "R10";

  always #5 clk = ~clk;

  legacy_mem_router uut (.*);

  function automatic void model(input logic v, input logic [31:0] a, input logic wr,
                                input logic smm, input logic fb,
                                output logic [2:0] e, output string tag);
    int idx;
    bit ok;
    e = 3'b000;
    if (!v) begin tag = "R10"; return; end
    if (a >= 32'h100000) begin tag = "R9"; return; end
    if (a < 32'h80000) begin e = 3'b100; tag = "R2"; return; end
    if (a < 32'hA0000) begin e = mHole ? 3'b010 : 3'b100; tag = "R3"; return; end
    if (a < 32'hC0000) begin
      if (fb) begin e = mSmram ? 3'b001 : 3'b010; tag = "R6"; end
      else if (smm) begin e = mSmram ? 3'b100 : 3'b010; tag = "R5"; end
      else begin e = 3'b010; tag = "R4"; end
      return;
    end
    if (a < 32'hE0000) idx = int'((a - 32'hC0000) / 32'h4000);
    else if (a < 32'hF0000) idx = 8 + int'((a - 32'hE0000) / 32'h4000);
    else idx = 12;
    ok = wr ? mWr[idx] : mRd[idx];
    e = ok ? 3'b100 : 3'b010;
    tag = "R8/R7";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // compare on every falling edge (outputs settled since the rising edge)
  always @(negedge clk) begin
    if (rstN && !done) check(expTag, {toDram, toBus, denied}, expOut);
  end

  task automatic req(input logic [31:0] a, input logic wr, input logic smm, input logic fb,
                     input logic v = 1'b1);
    logic [2:0] e;
    string t;
    reqValid = v; reqAddr = a; reqWrite = wr; reqSmm = smm; reqFromBus = fb;
    cfgWrEn = 1'b0;
    model(v, a, wr, smm, fb, e, t);
    @(posedge clk);
    expOut = e; expTag = t;
    @(negedge clk);
    #1;
  endtask

  task automatic cfgWrite(input int idx, input logic [7:0] d);
    reqValid = 1'b0; cfgWrEn = 1'b1; cfgAddr = 4'(idx); cfgWrData = d;
    @(posedge clk);
    expOut = 3'b000; expTag = "R10";
    if (idx == 0) begin mHole = d[0]; mSmram = d[1]; end
    else if (idx <= 13) begin mRd[idx-1] = d[0]; mWr[idx-1] = d[1]; end
    @(negedge clk);
    #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgCheck(input int idx, input string tag);
    int exp;
    cfgAddr = 4'(idx);
    #1;
    if (idx == 0) exp = {mSmram, mHole};
    else if (idx <= 13) exp = {mWr[idx-1], mRd[idx-1]};
    else exp = 0;
    check(tag, cfgRdData, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 13; i++) begin mRd[i] = 0; mWr[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check("R1", {toDram, toBus, denied}, 0);
    for (int i = 0; i < 16; i++) cfgCheck(i, "R1");

    // default configuration
    req(32'h00000, 0, 0, 0);
    req(32'h7FFFF, 1, 0, 0);
    req(32'h80000, 0, 0, 0);
    req(32'h9FFFF, 1, 0, 0);
    req(32'hA0000, 0, 0, 0);
    req(32'hB0000, 1, 1, 0);
    req(32'hA8000, 0, 0, 1);
    req(32'hC0000, 0, 0, 0);
    req(32'hF0000, 1, 0, 0);
    req(32'h100000, 0, 0, 0);
    req(32'hFFFFFFFF, 1, 1, 1);
    req(32'h00000, 0, 0, 0, 1'b0);

    // program hole, SMRAM and a few attributes
    cfgWrite(0, 8'hFF);
    cfgWrite(1, 8'h01);
    cfgWrite(8, 8'h01);
    cfgWrite(9, 8'h02);
    cfgWrite(13, 8'h03);
    cfgWrite(14, 8'h03);
    cfgWrite(15, 8'hFF);
    for (int i = 0; i < 16; i++) cfgCheck(i, "R11");

    req(32'h00000, 1, 0, 0);
    req(32'h80000, 0, 0, 0);
    req(32'h90000, 1, 1, 0);
    req(32'hA0000, 0, 0, 0);
    req(32'hA0000, 0, 1, 0);
    req(32'hBFFFF, 1, 1, 0);
    req(32'hA0000, 0, 0, 1);
    req(32'hA0000, 1, 1, 1);
    req(32'hC0000, 0, 0, 0);
    req(32'hC0000, 1, 0, 0);
    req(32'hC4000, 0, 0, 0);
    req(32'hDC000, 0, 0, 0);
    req(32'hE0000, 1, 0, 0);
    req(32'hE0000, 0, 0, 0);
    req(32'hE4000, 1, 0, 0);
    req(32'hF0000, 0, 0, 0);
    req(32'hFFFFF, 1, 0, 0);

    // SMRAM off, hole off
    cfgWrite(0, 8'h00);
    req(32'hA0000, 0, 1, 0);
    req(32'hA0000, 0, 0, 1);
    req(32'h80000, 1, 0, 0);

    // R7/R8 sweep: distinct attribute pattern per segment
    for (int i = 1; i <= 13; i++) cfgWrite(i, 8'((i * 7 + 1) % 4));
    for (int i = 1; i <= 13; i++) cfgCheck(i, "R11");
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 2; w++) begin
        req(32'hC0000 + 32'(s) * 32'h4000, 1'(w), 0, 0);
        req(32'hC0000 + 32'(s) * 32'h4000 + 32'h3FFF, 1'(w), 0, 1);
      end
    end
    req(32'h0, 0, 0, 0, 1'b0);
    @(negedge clk);
    finishRun();
  end
endmodule